// File: doc/BRIEF.md
# Factory-restore service request controller

This controller runs a return-to-factory request across two system resets. A privileged bus write to the request register arms the command and immediately asks the chip for a system reset. When the reset pulse has ended and the reset initialization reports that it is finished, the controller looks at the armed command. It then either starts an external restore routine and waits for that routine's done/result handshake, or it rejects the command. The outcome is stored as a completion code, and a second system reset follows.

The request register, the completion code and the reset-cause flag are cleared only by the power-on reset `rst_ni`. They therefore survive the two resets that the controller itself requests. Software reads the completion code and the cause flag after the second reset. It clears the cause flag by writing 0 to it.

Top module: `fsr_ctrl`

## Requirements
- R1: A write to the request register (address 0) with `bus_priv_i` low is ignored. No reset is requested and the register reads back unchanged.
- R2: A privileged write to address 0 with data bit 0 (go) set, made while the controller is idle, is accepted at that clock edge. `sys_rst_o` is high from the next cycle for exactly RST_CYC cycles, and the cause flag (address 1, bit 0) reads 1. A privileged write with go clear is ignored.
- R3: `restore_run_o` stays low while `sys_rst_o` is high, and it stays low after the reset until `init_done_i` has been sampled high.
- R4: If the armed command (write data bits 3:1) equals CMD_RESTORE, `restore_run_o` is high from the cycle after `init_done_i` is sampled until `restore_done_i` is sampled. `restore_ok_i` at that edge selects completion code 01 (success) or 10 (failure).
- R5: Any other command is rejected in one cycle with completion code 11, and `restore_run_o` is never raised.
- R6: One cycle after the outcome is known, the code is written, the armed bit clears, the cause flag is set again, and a second RST_CYC-cycle reset follows. The code is then kept while idle.
- R7: The busy bit (address 0, bit 7) reads 1 in every state except idle. A write to address 0 while busy is ignored.
- R8: Any write to address 1 with data bit 0 clear clears the cause flag. Writing 1 leaves the flag unchanged. A reset being set in the same cycle wins over the clear.
- R9: Power-on reset (`rst_ni` low) clears the sequence, the armed bit, the command, the completion code and the cause flag, and it drops `sys_rst_o` and `restore_run_o`.
- R10: An accepted request sets the completion code to 00 (none).
- R11: Read map. Address 0 returns armed in bit 0, the completion code in bits 2:1, the command in bits 5:3 and busy in bit 7, with all other bits 0. Address 1 returns the cause flag in bit 0, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 1 | 0 = request register, 1 = reset-cause register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_priv_i | input | 1 | Access is privileged |
| bus_rdata_o | output | DATA_W | Read data for `bus_addr_i`, combinational |
| init_done_i | input | 1 | Reset initialization has finished |
| restore_run_o | output | 1 | Restore routine requested, held until done |
| restore_done_i | input | 1 | Restore routine finished |
| restore_ok_i | input | 1 | Restore outcome, 1 = success, sampled with done |
| sys_rst_o | output | 1 | System reset request |

## Verification
The bench builds the block with RST_CYC = 5, so that both resets are short enough to run several complete sequences. It sets CMD_RESTORE = 5 rather than the default of 1, which makes the command field carry a multi-bit value that is non-zero at both ends. This shows that accepted, rejected and ignored commands are told apart by the decode of bits 3:1 and not by a single bit. Init-done delays of 0 to 6 cycles and restore delays of 0 to 3 cycles exercise the wait states and the same-cycle outcome path. A power-on reset during a sequence covers the persistent-domain clear.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int unsigned CMD_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESET1,
    ST_INIT_WAIT,
    ST_PROCESS,
    ST_REPORT,
    ST_RESET2
  } fsr_state_e;

  typedef enum logic [1:0] {
    CC_NONE   = 2'b00,
    CC_OK     = 2'b01,
    CC_FAIL   = 2'b10,
    CC_REJECT = 2'b11
  } fsr_code_e;

  // register field positions
  localparam int unsigned WR_GO_BIT   = 0;
  localparam int unsigned WR_CMD_LSB  = 1;
  localparam int unsigned RD_ARM_BIT  = 0;
  localparam int unsigned RD_CODE_LSB = 1;
  localparam int unsigned RD_CMD_LSB  = 3;
  localparam int unsigned RD_BUSY_BIT = 7;
endpackage

// File: rtl/fsr_rst_timer.sv
module fsr_rst_timer #(
  parameter int unsigned CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic last_o
);
  localparam int unsigned CW = (CYC > 1) ? $clog2(CYC) : 1;

  logic [CW-1:0] cnt_q;
  logic          active_q;

  assign active_o = active_q;
  assign last_o   = active_q && (cnt_q == CW'(CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (last_o) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_RST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !last_o |=> active_q); // R2
  AST_RST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !start_i |=> !active_q); // R2
  AST_RST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q); // R6
endmodule

// File: rtl/fsr_seq.sv
module fsr_seq
  import fsr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       arm_i,
  input  logic       rst_last_i,
  input  logic       init_done_i,
  input  logic       cmd_ok_i,
  input  logic       restore_done_i,
  input  logic       restore_ok_i,
  output fsr_state_e state_o,
  output logic       timer_start_o,
  output logic       run_o,
  output logic       report_o,
  output fsr_code_e  res_o
);
  fsr_state_e state_q, state_d;
  fsr_code_e  res_q, res_d;

  assign state_o       = state_q;
  assign res_o         = res_q;
  assign report_o      = (state_q == ST_REPORT);
  assign run_o         = (state_q == ST_PROCESS) && cmd_ok_i;
  assign timer_start_o = arm_i || report_o;

  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    unique case (state_q)
      ST_IDLE:      if (arm_i) state_d = ST_RESET1;
      ST_RESET1:    if (rst_last_i) state_d = ST_INIT_WAIT;
      ST_INIT_WAIT: if (init_done_i) state_d = ST_PROCESS;
      ST_PROCESS: begin
        if (!cmd_ok_i) begin
          res_d   = CC_REJECT;
          state_d = ST_REPORT;
        end else if (restore_done_i) begin
          res_d   = restore_ok_i ? CC_OK : CC_FAIL;
          state_d = ST_REPORT;
        end
      end
      ST_REPORT:    state_d = ST_RESET2;
      ST_RESET2:    if (rst_last_i) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      res_q   <= CC_NONE;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
    end
  end

  AST_INIT_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_INIT_WAIT && !init_done_i |=> state_q == ST_INIT_WAIT); // R3
  AST_REJECT_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_PROCESS && !cmd_ok_i |=> state_q == ST_REPORT && res_q == CC_REJECT); // R5
  AST_REPORT_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    report_o |=> state_q == ST_RESET2); // R6
endmodule

// File: rtl/fsr_regs.sv
module fsr_regs
  import fsr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic              bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_priv_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              idle_i,
  input  logic              report_i,
  input  fsr_code_e         res_i,
  output logic              arm_o,
  output logic [CMD_W-1:0]  cmd_o
);
  logic             wr;
  logic             cause_clr;
  logic             armed_q;
  logic [CMD_W-1:0] cmd_q;
  fsr_code_e        code_q;
  logic             cause_q;
  logic             unused_wdata;

  assign wr        = bus_req_i && bus_we_i;
  assign arm_o     = wr && !bus_addr_i && bus_priv_i && bus_wdata_i[WR_GO_BIT] && idle_i;
  assign cause_clr = wr && bus_addr_i && !bus_wdata_i[WR_GO_BIT];
  assign cmd_o     = cmd_q;
  assign unused_wdata = ^bus_wdata_i[DATA_W-1:WR_CMD_LSB+CMD_W];

  // persistent domain: only power-on clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cmd_q   <= '0;
      code_q  <= CC_NONE;
      cause_q <= 1'b0;
    end else begin
      if (arm_o) begin
        armed_q <= 1'b1;
        cmd_q   <= bus_wdata_i[WR_CMD_LSB +: CMD_W];
        code_q  <= CC_NONE;
      end else if (report_i) begin
        armed_q <= 1'b0;
        code_q  <= res_i;
      end
      if (arm_o || report_i) cause_q <= 1'b1;
      else if (cause_clr)    cause_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i) begin
      bus_rdata_o[0] = cause_q;
    end else begin
      bus_rdata_o[RD_ARM_BIT]                = armed_q;
      bus_rdata_o[RD_CODE_LSB +: 2]          = code_q;
      bus_rdata_o[RD_CMD_LSB +: CMD_W]       = cmd_q;
      bus_rdata_o[RD_BUSY_BIT]               = !idle_i;
    end
  end

  AST_UNPRIV_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && !bus_addr_i && !bus_priv_i && !report_i
      |=> $stable(armed_q) && $stable(cmd_q) && $stable(code_q)); // R1
  AST_BUSY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && !bus_addr_i && !idle_i |=> $stable(cmd_q)); // R7
  AST_CAUSE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_o || report_i |=> cause_q); // R2
  AST_CAUSE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_clr && !arm_o && !report_i |=> !cause_q); // R8
endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
#(
  parameter int unsigned      DATA_W      = 8,
  parameter int unsigned      RST_CYC     = 16,
  parameter logic [CMD_W-1:0] CMD_RESTORE = 3'd1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic              bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_priv_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              init_done_i,
  output logic              restore_run_o,
  input  logic              restore_done_i,
  input  logic              restore_ok_i,
  output logic              sys_rst_o
);
  fsr_state_e       state;
  fsr_code_e        res;
  logic             arm;
  logic             timer_start;
  logic             rst_last;
  logic             report;
  logic [CMD_W-1:0] cmd;

  fsr_rst_timer #(.CYC(RST_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (timer_start),
    .active_o (sys_rst_o),
    .last_o   (rst_last)
  );

  fsr_seq u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .arm_i          (arm),
    .rst_last_i     (rst_last),
    .init_done_i    (init_done_i),
    .cmd_ok_i       (cmd == CMD_RESTORE),
    .restore_done_i (restore_done_i),
    .restore_ok_i   (restore_ok_i),
    .state_o        (state),
    .timer_start_o  (timer_start),
    .run_o          (restore_run_o),
    .report_o       (report),
    .res_o          (res)
  );

  fsr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_req_i   (bus_req_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_priv_i  (bus_priv_i),
    .bus_rdata_o (bus_rdata_o),
    .idle_i      (state == ST_IDLE),
    .report_i    (report),
    .res_i       (res),
    .arm_o       (arm),
    .cmd_o       (cmd)
  );

  AST_RUN_OUTSIDE_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sys_rst_o && restore_run_o)); // R3
endmodule

// File: tb/fsr_ctrl_test.sv
module fsr_ctrl_test;
  localparam int CLK_PERIOD  = 10;
  localparam int DATA_W      = 8;
  localparam int RST_CYC     = 5;
  localparam logic [2:0] CMD_RESTORE = 3'd5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_req_i = 1'b0, bus_we_i = 1'b0, bus_addr_i = 1'b0, bus_priv_i = 1'b0;
  logic [DATA_W-1:0] bus_wdata_i = '0;
  logic [DATA_W-1:0] bus_rdata_o;
  logic init_done_i = 1'b1;
  logic restore_run_o, restore_done_i = 1'b0, restore_ok_i;
  logic sys_rst_o;

  int n_tests = 0, n_fail = 0;
  int stub_delay = 0, stub_cnt = 0, init_delay = 0, init_cnt = 0;
  logic stub_ok = 1'b1, run_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsr_ctrl #(.DATA_W(DATA_W), .RST_CYC(RST_CYC), .CMD_RESTORE(CMD_RESTORE)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_req_i(bus_req_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_priv_i(bus_priv_i),
    .bus_rdata_o(bus_rdata_o), .init_done_i(init_done_i), .restore_run_o(restore_run_o),
    .restore_done_i(restore_done_i), .restore_ok_i(restore_ok_i), .sys_rst_o(sys_rst_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model: 0 idle,1 first reset,2 init wait,3 process,4 report,5 second reset
  int         m_st = 0, m_left = 0;
  logic       m_armed = 0, m_cause = 0;
  logic [1:0] m_code = 0, m_res = 0;
  logic [2:0] m_cmd = 0;
  logic       m_wr, m_arm, m_clr, m_rst, m_run;
  logic [7:0] m_rdata;

  assign m_wr  = bus_req_i && bus_we_i;
  assign m_arm = m_wr && !bus_addr_i && bus_priv_i && bus_wdata_i[0] && m_st == 0;
  assign m_clr = m_wr && bus_addr_i && !bus_wdata_i[0];
  assign m_rst = (m_st == 1) || (m_st == 5);
  assign m_run = (m_st == 3) && (m_cmd == CMD_RESTORE);
  assign m_rdata = bus_addr_i ? {7'd0, m_cause}
                              : {(m_st != 0), 1'b0, m_cmd, m_code, m_armed};

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st <= 0; m_left <= 0; m_armed <= 0; m_cause <= 0;
      m_code <= 0; m_res <= 0; m_cmd <= 0;
    end else begin
      case (m_st)
        0: if (m_arm) begin
             m_st <= 1; m_left <= RST_CYC; m_armed <= 1;
             m_cmd <= bus_wdata_i[3:1]; m_code <= 2'b00;
           end
        1, 5: if (m_left == 1) m_st <= (m_st == 1) ? 2 : 0; else m_left <= m_left - 1;
        2: if (init_done_i) m_st <= 3;
        3: if (m_cmd != CMD_RESTORE) begin m_res <= 2'b11; m_st <= 4; end
           else if (restore_done_i) begin m_res <= restore_ok_i ? 2'b01 : 2'b10; m_st <= 4; end
        4: begin m_st <= 5; m_left <= RST_CYC; m_code <= m_res; m_armed <= 0; end
        default: m_st <= 0;
      endcase
      if (m_arm || m_st == 4) m_cause <= 1;
      else if (m_clr)         m_cause <= 0;
    end
  end

  // per-cycle comparison against the model
  always begin
    @(negedge clk);
    #1;
    check("R2/R6 sys_rst_o per-cycle", sys_rst_o, m_rst);
    check("R4 restore_run_o per-cycle", restore_run_o, m_run);
    check("R11 bus_rdata_o per-cycle", bus_rdata_o, m_rdata);
  end

  // stub restore routine and reset-initialization source
  assign restore_ok_i = stub_ok;
  always @(negedge clk) begin
    if (restore_run_o) begin
      run_seen = 1'b1;
      restore_done_i = (stub_cnt == stub_delay);
      stub_cnt++;
    end else begin
      stub_cnt = 0;
      restore_done_i = 1'b0;
    end
    if (sys_rst_o) begin
      init_cnt = 0;
      init_done_i = 1'b0;
    end else begin
      if (init_cnt < init_delay) init_cnt++;
      init_done_i = (init_cnt >= init_delay);
    end
  end

  task automatic bus_write(logic a, logic [7:0] d, logic p);
    @(negedge clk);
    bus_req_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d; bus_priv_i = p;
    @(negedge clk);
    bus_req_i = 0; bus_we_i = 0; bus_priv_i = 0;
  endtask

  task automatic bus_read(logic a, logic [7:0] exp, string tag);
    @(negedge clk);
    bus_addr_i = a;
    #2;
    check(tag, bus_rdata_o, exp);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      bus_addr_i = 0;
      #2;
      if (!bus_rdata_o[7]) break;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired, all requirements: actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    bus_read(0, 8'h00, "R9 request reg after power-on");
    bus_read(1, 8'h00, "R9 cause after power-on");

    // R1: unprivileged request ignored
    bus_write(0, 8'h0B, 0);
    repeat (3) @(negedge clk);
    check("R1 no reset on unprivileged write", sys_rst_o, 1'b0);
    bus_read(0, 8'h00, "R1 request reg unchanged");
    // R2: go bit clear ignored
    bus_write(0, 8'h0A, 1);
    check("R2 no reset without go bit", sys_rst_o, 1'b0);
    bus_read(0, 8'h00, "R2 request reg unchanged without go");

    // success path
    stub_delay = 3; stub_ok = 1; init_delay = 2;
    bus_write(0, 8'h0B, 1);
    check("R2 reset asserted after accept", sys_rst_o, 1'b1);
    bus_read(0, 8'hA9, "R7 busy, armed, cmd during first reset");
    bus_read(1, 8'h01, "R2 cause set");
    bus_write(0, 8'h03, 1);
    bus_read(0, 8'hA9, "R7 write while busy ignored");
    wait_idle();
    bus_read(0, 8'h2A, "R4 success code 01, R6 armed cleared");
    bus_read(1, 8'h01, "R6 cause set after second reset");

    // R8: cause clear rules
    bus_write(1, 8'h01, 1);
    bus_read(1, 8'h01, "R8 writing 1 keeps cause");
    bus_write(1, 8'h00, 0);
    bus_read(1, 8'h00, "R8 writing 0 clears cause");

    // failure path, R10
    stub_delay = 0; stub_ok = 0; init_delay = 4;
    bus_write(0, 8'h0B, 1);
    bus_read(0, 8'hA9, "R10 code cleared on new request");
    wait_idle();
    bus_read(0, 8'h2C, "R4 failure code 10");
    bus_read(1, 8'h01, "R6 cause after failure sequence");

    // R5: rejected command
    run_seen = 0; init_delay = 1;
    bus_write(0, 8'h03, 1);
    wait_idle();
    bus_read(0, 8'h0E, "R5 reject code 11");
    check("R5 restore never requested", run_seen, 1'b0);

    // R3: hold off until init done
    init_delay = 6; stub_delay = 1; stub_ok = 1;
    bus_write(0, 8'h0B, 1);
    for (int i = 0; i < 50 && sys_rst_o; i++) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #1;
      check("R3 no restore before init done", restore_run_o, 1'b0);
    end
    wait_idle();
    bus_read(0, 8'h2A, "R4 success after long init");

    // R9: power-on reset mid-sequence
    bus_write(0, 8'h0B, 1);
    repeat (2) @(negedge clk);
    rst_ni = 0;
    #2;
    check("R9 sys_rst_o dropped by power-on", sys_rst_o, 1'b0);
    bus_addr_i = 0;
    #1;
    check("R9 request reg cleared", bus_rdata_o, 8'h00);
    bus_addr_i = 1;
    #1;
    check("R9 cause cleared", bus_rdata_o, 8'h00);
    @(negedge clk);
    rst_ni = 1;
    bus_read(0, 8'h00, "R9 idle after release");

    summary();
    $finish;
  end
endmodule